// File: doc/BRIEF.md
# Sync-Referenced Video Timing Generator

This block produces horizontal and vertical sync, a border window, a display-enable window and a cursor window for a raster display. Two free-running counters, one per axis, define the raster position. Their zero point is the leading edge of the sync pulse, not the first visible pixel. Every window is set by a pair of offsets measured from that edge.

Software loads the timing through a simple write port. Timing values first land in a pending bank. They are copied into the active bank only when a frame ends, so a frame is never built from a mix of old and new values. A separate output-control word applies from the next cycle. It sets the polarity of each sync and gates the visible windows.

Top module: `sync_video_timer`

## Requirements
- R1: While reset is high, and in the first cycle after it, both counters are zero and the power-up timing is active. With that timing hsync_o and vsync_o are 1, border_o, display_o and cursor_o are 0, and the output-control word has only its enable bit set.
- R2: The horizontal counter runs 0 .. line_total-1 and then wraps. line_total is the horizontal cycle value plus 8. hsync is asserted while the counter is below the horizontal sync-width value.
- R3: The vertical counter advances once per horizontal wrap and runs 0 .. frame_total-1, where frame_total is the vertical cycle value plus 1. vsync is asserted while the vertical counter is below the vertical sync-width value.
- R4: border_o is 1 when the horizontal counter is in [h border start, h border end) and the vertical counter is in [v border start, v border end).
- R5: display_o is 1 when both counters lie inside their own [display start, display end) windows.
- R6: cursor_o is 1 when the horizontal counter is in [h cursor start, h cursor start + CURSOR_W) and the vertical counter is in [v cursor start, v cursor end).
- R7: Bit 0 of a written value is dropped for the horizontal sync-width, border and display registers, so these values are always even.
- R8: Bits [1:0] of a written horizontal cycle value are dropped, so a line is always a multiple of 4 clocks.
- R9: A timing write goes to a pending copy. The copy becomes active in the first cycle of the next frame, after the last clock of the last line.
- R10: Output-control bit 16 inverts hsync_o and bit 18 inverts vsync_o. Each takes effect in the cycle after the write.
- R11: When output-control bit 12 is 0, border_o, display_o and cursor_o stay 0 while both syncs keep running. Writing 0 to the whole word blanks the display.
- R12: Register addresses are: 0 h cycle, 1 h sync width, 2 h border start, 3 h display start, 4 h display end, 5 h border end, 6 h cursor start, 7 output control, 8 v cycle, 9 v sync width, 10 v border start, 11 v display start, 12 v display end, 13 v border end, 14 v cursor start, 15 v cursor end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 32 | Write data |
| hsync_o | output | 1 | Horizontal sync, polarity per control word |
| vsync_o | output | 1 | Vertical sync, polarity per control word |
| border_o | output | 1 | Border window active |
| display_o | output | 1 | Display window active |
| cursor_o | output | 1 | Cursor window active |

## Verification
The generator first runs on the power-up timing. It is then given a second timing with odd low bits in every horizontal value and a longer line and frame. This shows whether the masking works and whether each window edge is taken from the sync-referenced offset. That second timing is written in the middle of a frame, which tells deferred loading apart from immediate loading: the line length just after the writes must still be the old one. The output-control word is then stepped through hsync inversion, vsync inversion and full blanking, which separates polarity effects from the enable gate. A cycle-by-cycle reference model checks all five outputs against every one of these patterns.

// File: rtl/svt_pkg.sv
package svt_pkg;

    parameter int H_W    = 12;
    parameter int V_W    = 12;
    parameter int DATA_W = 32;
    parameter int ADDR_W = 4;

    localparam int CTL_EN_BIT   = 12;
    localparam int CTL_HINV_BIT = 16;
    localparam int CTL_VINV_BIT = 18;
    localparam int H_TOTAL_ADD  = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_H_CYC  = 4'd0,  RA_H_SYNC = 4'd1,  RA_H_BST  = 4'd2,  RA_H_DST  = 4'd3,
        RA_H_DEND = 4'd4,  RA_H_BEND = 4'd5,  RA_H_CUR  = 4'd6,  RA_CTL    = 4'd7,
        RA_V_CYC  = 4'd8,  RA_V_SYNC = 4'd9,  RA_V_BST  = 4'd10, RA_V_DST  = 4'd11,
        RA_V_DEND = 4'd12, RA_V_BEND = 4'd13, RA_V_CST  = 4'd14, RA_V_CEND = 4'd15
    } reg_addr_e;

    typedef struct packed {
        logic [H_W-1:0] cyc;
        logic [H_W-1:0] sync;
        logic [H_W-1:0] bst;
        logic [H_W-1:0] dst;
        logic [H_W-1:0] dend;
        logic [H_W-1:0] bend;
        logic [H_W-1:0] cur;
    } h_tim_t;

    typedef struct packed {
        logic [V_W-1:0] cyc;
        logic [V_W-1:0] sync;
        logic [V_W-1:0] bst;
        logic [V_W-1:0] dst;
        logic [V_W-1:0] dend;
        logic [V_W-1:0] bend;
        logic [V_W-1:0] cst;
        logic [V_W-1:0] cend;
    } v_tim_t;

    typedef struct packed {
        logic en;
        logic hinv;
        logic vinv;
    } ctl_t;

    localparam h_tim_t H_DEFAULT = '{cyc: H_W'(24), sync: H_W'(4), bst: H_W'(2),
                                     dst: H_W'(6), dend: H_W'(26), bend: H_W'(30),
                                     cur: H_W'(10)};
    localparam v_tim_t V_DEFAULT = '{cyc: V_W'(9), sync: V_W'(1), bst: V_W'(1),
                                     dst: V_W'(2), dend: V_W'(8), bend: V_W'(9),
                                     cst: V_W'(3), cend: V_W'(5)};
    localparam ctl_t CTL_DEFAULT = '{en: 1'b1, hinv: 1'b0, vinv: 1'b0};

    function automatic logic [H_W:0] line_total(input h_tim_t t);
        return {1'b0, t.cyc} + (H_W+1)'(H_TOTAL_ADD);
    endfunction

    function automatic logic [V_W:0] frame_total(input v_tim_t t);
        return {1'b0, t.cyc} + (V_W+1)'(1);
    endfunction

    function automatic logic [H_W-1:0] even_only(input logic [DATA_W-1:0] d);
        return d[H_W-1:0] & ~H_W'(1);
    endfunction

endpackage

// File: rtl/svt_regfile.sv
module svt_regfile
    import svt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              frame_end_i,
    output h_tim_t            act_h_o,
    output v_tim_t            act_v_o,
    output ctl_t              ctl_o
);

    h_tim_t pend_h;
    v_tim_t pend_v;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_h  <= H_DEFAULT;
            pend_v  <= V_DEFAULT;
            act_h_o <= H_DEFAULT;
            act_v_o <= V_DEFAULT;
            ctl_o   <= CTL_DEFAULT;
        end else begin
            if (frame_end_i) begin
                act_h_o <= pend_h;
                act_v_o <= pend_v;
            end
            if (wr_en_i) begin
                case (reg_addr_e'(wr_addr_i))
                    RA_H_CYC:  pend_h.cyc  <= wr_data_i[H_W-1:0] & ~H_W'(3);
                    RA_H_SYNC: pend_h.sync <= even_only(wr_data_i);
                    RA_H_BST:  pend_h.bst  <= even_only(wr_data_i);
                    RA_H_DST:  pend_h.dst  <= even_only(wr_data_i);
                    RA_H_DEND: pend_h.dend <= even_only(wr_data_i);
                    RA_H_BEND: pend_h.bend <= even_only(wr_data_i);
                    RA_H_CUR:  pend_h.cur  <= wr_data_i[H_W-1:0];
                    RA_CTL:    ctl_o <= '{en:   wr_data_i[CTL_EN_BIT],
                                          hinv: wr_data_i[CTL_HINV_BIT],
                                          vinv: wr_data_i[CTL_VINV_BIT]};
                    RA_V_CYC:  pend_v.cyc  <= wr_data_i[V_W-1:0];
                    RA_V_SYNC: pend_v.sync <= wr_data_i[V_W-1:0];
                    RA_V_BST:  pend_v.bst  <= wr_data_i[V_W-1:0];
                    RA_V_DST:  pend_v.dst  <= wr_data_i[V_W-1:0];
                    RA_V_DEND: pend_v.dend <= wr_data_i[V_W-1:0];
                    RA_V_BEND: pend_v.bend <= wr_data_i[V_W-1:0];
                    RA_V_CST:  pend_v.cst  <= wr_data_i[V_W-1:0];
                    RA_V_CEND: pend_v.cend <= wr_data_i[V_W-1:0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/svt_axis_cnt.sv
module svt_axis_cnt #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         step_i,
    input  logic [W:0]   total_i,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);

    assign last_o = ({1'b0, cnt_o} == (total_i - (W+1)'(1)));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o <= '0;
        end else if (step_i) begin
            cnt_o <= last_o ? '0 : cnt_o + W'(1);
        end
    end

endmodule

// File: rtl/svt_span.sv
module svt_span #(
    parameter int W = 12
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] lo_i,
    input  logic [W:0]   hi_i,
    output logic         in_o
);

    assign in_o = (cnt_i >= lo_i) && ({1'b0, cnt_i} < hi_i);

endmodule

// File: rtl/sync_video_timer.sv
module sync_video_timer
    import svt_pkg::*;
#(
    parameter int CURSOR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              border_o,
    output logic              display_o,
    output logic              cursor_o
);

    localparam int N_WIN = 3;

    h_tim_t         act_h;
    v_tim_t         act_v;
    ctl_t           ctl_q;
    logic [H_W-1:0] hcnt;
    logic [V_W-1:0] vcnt;
    logic           h_last;
    logic           v_last;
    logic           frame_end;
    logic           ctl_en;
    logic           ctl_hinv;
    logic           ctl_vinv;

    assign frame_end = h_last & v_last;
    assign ctl_en    = ctl_q.en;
    assign ctl_hinv  = ctl_q.hinv;
    assign ctl_vinv  = ctl_q.vinv;

    svt_regfile u_regs (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .frame_end_i (frame_end),
        .act_h_o     (act_h),
        .act_v_o     (act_v),
        .ctl_o       (ctl_q)
    );

    svt_axis_cnt #(.W(H_W)) u_hcnt (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .step_i  (1'b1),
        .total_i (line_total(act_h)),
        .cnt_o   (hcnt),
        .last_o  (h_last)
    );

    svt_axis_cnt #(.W(V_W)) u_vcnt (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .step_i  (h_last),
        .total_i (frame_total(act_v)),
        .cnt_o   (vcnt),
        .last_o  (v_last)
    );

    // window 0: border, 1: display, 2: cursor
    logic [H_W-1:0] h_lo [N_WIN];
    logic [H_W:0]   h_hi [N_WIN];
    logic [V_W-1:0] v_lo [N_WIN];
    logic [V_W:0]   v_hi [N_WIN];
    logic [N_WIN-1:0] h_in;
    logic [N_WIN-1:0] v_in;

    always_comb begin
        h_lo[0] = act_h.bst;  h_hi[0] = {1'b0, act_h.bend};
        h_lo[1] = act_h.dst;  h_hi[1] = {1'b0, act_h.dend};
        h_lo[2] = act_h.cur;  h_hi[2] = {1'b0, act_h.cur} + (H_W+1)'(CURSOR_W);
        v_lo[0] = act_v.bst;  v_hi[0] = {1'b0, act_v.bend};
        v_lo[1] = act_v.dst;  v_hi[1] = {1'b0, act_v.dend};
        v_lo[2] = act_v.cst;  v_hi[2] = {1'b0, act_v.cend};
    end

    for (genvar gi = 0; gi < N_WIN; gi++) begin : g_win
        svt_span #(.W(H_W)) u_hspan (
            .cnt_i (hcnt), .lo_i (h_lo[gi]), .hi_i (h_hi[gi]), .in_o (h_in[gi])
        );
        svt_span #(.W(V_W)) u_vspan (
            .cnt_i (vcnt), .lo_i (v_lo[gi]), .hi_i (v_hi[gi]), .in_o (v_in[gi])
        );
    end

    assign hsync_o   = (hcnt < act_h.sync) ^ ctl_hinv;
    assign vsync_o   = (vcnt < act_v.sync) ^ ctl_vinv;
    assign border_o  = ctl_en & h_in[0] & v_in[0];
    assign display_o = ctl_en & h_in[1] & v_in[1];
    assign cursor_o  = ctl_en & h_in[2] & v_in[2];

endmodule

// File: rtl/svt_checker.sv
module svt_checker
    import svt_pkg::*;
(
    input logic           clk_i,
    input logic           rst_i,
    input logic [H_W-1:0] hcnt_i,
    input logic [V_W-1:0] vcnt_i,
    input logic           h_last_i,
    input logic           frame_end_i,
    input h_tim_t         act_h_i,
    input v_tim_t         act_v_i,
    input logic           ctl_en_i,
    input logic           ctl_hinv_i,
    input logic           hsync_i,
    input logic           border_i,
    input logic           display_i,
    input logic           cursor_i
);

    a_r1_zero_after_reset: assert property (@(posedge clk_i)
        rst_i |=> (hcnt_i == '0) && (vcnt_i == '0));

    a_r2_h_advance: assert property (@(posedge clk_i) disable iff (rst_i)
        !h_last_i |=> hcnt_i == $past(hcnt_i) + H_W'(1));

    a_r2_h_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        h_last_i |=> hcnt_i == '0);

    a_r3_v_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !h_last_i |=> $stable(vcnt_i));

    a_r9_timing_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_end_i |=> $stable(act_h_i) && $stable(act_v_i));

    a_r11_blank: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctl_en_i |-> !border_i && !display_i && !cursor_i);

    a_r10_hsync_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (hcnt_i >= act_h_i.sync) |-> (hsync_i == ctl_hinv_i));

endmodule

bind sync_video_timer svt_checker u_svt_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .hcnt_i      (hcnt),
    .vcnt_i      (vcnt),
    .h_last_i    (h_last),
    .frame_end_i (frame_end),
    .act_h_i     (act_h),
    .act_v_i     (act_v),
    .ctl_en_i    (ctl_en),
    .ctl_hinv_i  (ctl_hinv),
    .hsync_i     (hsync_o),
    .border_i    (border_o),
    .display_i   (display_o),
    .cursor_i    (cursor_o)
);

// File: tb/sync_video_timer_tb.sv
module sync_video_timer_tb_top;

    localparam int CUR_W = 8;
    localparam int EN_B  = 1 << 12;
    localparam int HI_B  = 1 << 16;
    localparam int VI_B  = 1 << 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, border, display, cursor;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #5 clk = ~clk;

    sync_video_timer #(.CURSOR_W(CUR_W)) dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .hsync_o(hsync), .vsync_o(vsync),
        .border_o(border), .display_o(display), .cursor_o(cursor)
    );

    // reference model state, indexed by register address (R12)
    int m_act [16];
    int m_pend[16];
    int m_ctl;
    int hc, vc;
    logic [4:0] exp_q[$];

    function automatic void load_defaults();
        int d[16] = '{24, 4, 2, 6, 26, 30, 10, 0, 9, 1, 1, 2, 8, 9, 3, 5};
        foreach (d[i]) begin m_act[i] = d[i]; m_pend[i] = d[i]; end
        m_ctl = EN_B;
    endfunction

    function automatic int store_val(int a, int d);
        if (a == 0) return d & 'hFFC;                  // R8
        if (a >= 1 && a <= 5) return d & 'hFFE;        // R7
        return d & 'hFFF;
    endfunction

    function automatic logic [4:0] expect_now();
        logic hs, vs, bo, di, cu, en;
        en = ((m_ctl & EN_B) != 0);
        hs = (hc < m_act[1]) ^ ((m_ctl & HI_B) != 0);
        vs = (vc < m_act[9]) ^ ((m_ctl & VI_B) != 0);
        bo = en && hc >= m_act[2] && hc < m_act[5] && vc >= m_act[10] && vc < m_act[13];
        di = en && hc >= m_act[3] && hc < m_act[4] && vc >= m_act[11] && vc < m_act[12];
        cu = en && hc >= m_act[6] && hc < m_act[6] + CUR_W && vc >= m_act[14] && vc < m_act[15];
        return {hs, vs, bo, di, cu};
    endfunction

    // model: mirrors each clock edge, pushes the expected outputs
    always @(posedge clk) begin
        #1;
        if (rst) begin
            load_defaults();
            hc = 0; vc = 0;
        end else begin
            int ltot, ftot;
            int old_pend[16];
            ltot = m_act[0] + 8;
            ftot = m_act[8] + 1;
            old_pend = m_pend;
            if (wr_en) begin
                if (wr_addr == 4'd7) m_ctl = wr_data & (EN_B | HI_B | VI_B);
                else m_pend[wr_addr] = store_val(int'(wr_addr), wr_data);
            end
            if (hc == ltot - 1) begin
                hc = 0;
                if (vc == ftot - 1) begin
                    vc = 0;
                    m_act = old_pend;
                    m_act[7] = 0;
                end else vc = vc + 1;
            end else hc = hc + 1;
        end
        exp_q.push_back(expect_now());
    end

    // monitor: pops and compares at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (exp_q.size() > 0) begin
            logic [4:0] e, a;
            string tags[5] = '{"R2/R7/R10", "R3/R10", "R4/R11", "R5/R9/R11", "R6"};
            e = exp_q.pop_front();
            a = {hsync, vsync, border, display, cursor};
            n_checks++;
            if (a !== e) begin
                n_fail++;
                for (int k = 0; k < 5; k++)
                    if (a[4-k] !== e[4-k])
                        $display("FAIL %s cycle %0d: actual %b expected %b", tags[k], cyc, a[4-k], e[4-k]);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(bit use_v, output int period, output int high);
        logic prev, cur;
        @(negedge clk); prev = use_v ? vsync : hsync;
        forever begin
            @(negedge clk); cur = use_v ? vsync : hsync;
            if (!prev && cur) break;
            prev = cur;
        end
        period = 0; high = 0;
        forever begin
            if (cur) high++;
            period++;
            prev = cur;
            @(negedge clk); cur = use_v ? vsync : hsync;
            if (!prev && cur) break;
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int p, h, blank_hits, rises;
        logic ph;
        repeat (4) @(negedge clk);
        // R1: outputs while in reset
        check("R1 hsync", hsync, 1); check("R1 vsync", vsync, 1);
        check("R1 windows", {border, display, cursor}, 0);
        rst = 1'b0;
        repeat (640) @(negedge clk);
        // odd low bits on every horizontal value (R7, R8), written mid-frame (R9)
        wr(0, 35); wr(1, 7); wr(2, 5); wr(3, 9); wr(4, 33); wr(5, 35); wr(6, 12);
        wr(8, 11); wr(9, 2); wr(10, 1); wr(11, 2); wr(12, 10); wr(13, 11);
        wr(14, 5); wr(15, 8);
        measure(0, p, h);
        check("R9 line length before boundary", p, 32);
        repeat (300) @(negedge clk);
        measure(0, p, h);
        check("R8 line length", p, 40);
        check("R7 hsync width", h, 6);
        measure(1, p, h);
        check("R3 frame length", p, 480);
        check("R3 vsync width", h, 80);
        // polarity (R10)
        wr(7, EN_B | HI_B);
        repeat (500) @(negedge clk);
        wr(7, EN_B | VI_B);
        repeat (500) @(negedge clk);
        // blanking (R11): windows stay low, hsync keeps toggling
        wr(7, 0);
        blank_hits = 0; rises = 0; ph = hsync;
        repeat (500) begin
            @(negedge clk);
            if (border || display || cursor) blank_hits++;
            if (!ph && hsync) rises++;
            ph = hsync;
        end
        check("R11 windows while blanked", blank_hits, 0);
        check("R11 hsync rises while blanked", rises, 12);
        wr(7, EN_B);
        repeat (500) @(negedge clk);
        finish_run();
    end

endmodule